// File: doc/BRIEF.md
# Latched Shift-Register Address Driver

This block drives a parallel memory device, such as an EPROM or a flash, whose address pins are fed by an external chain of serial-in shift registers. A request carries an address, a read-or-write flag and write data. The request is accepted on a valid/ready handshake. The block sends the address serially into the chain, most significant bit first, on a data pin and a shift-clock pin. When the chain has storage latches, the block then pulses a latch pin so that the memory sees the complete new address in one step. After that it strobes the memory once. A read returns the byte sampled from the memory bus, and every access ends with a one-cycle response pulse.

The latch can be turned off at build time. In that build the latch state is not generated. The chain outputs feed the memory directly and follow each bit as it shifts. In both builds, chip enable follows the union of output enable and write enable. Chip enable is therefore never active while the address on the memory pins can move.

Top module: `sr_addr_driver`

## Requirements
- R1: After reset, and until the first accepted request, `mem_ce`, `mem_oe`, `mem_we`, `mem_doe`, `sr_clk`, `sr_latch` and `rsp_valid` are low and `req_ready` is high.
- R2: Each access sends exactly ADDR_W bits. `sr_data` carries the address most significant bit first, and the external chain captures it on each rising edge of `sr_clk`. When the strobe starts, the address seen by the memory equals the requested address.
- R3: During shifting, each shift-clock period is SH_CYC system clocks low followed by SH_CYC system clocks high.
- R4: In the latched build, `sr_latch` rises in the same cycle that `sr_clk` falls for the last bit. It stays high for exactly 2*SH_CYC clocks while `sr_clk` stays low. The memory strobe rises in the cycle in which `sr_latch` falls.
- R5: In the latched build, the address presented to the memory changes only on a rising edge of `sr_latch`. It never changes while bits are being shifted.
- R6: In the build without a latch, `sr_latch` is never asserted. The memory strobe rises in the same cycle that `sr_clk` falls for the last bit.
- R7: `mem_ce` is high exactly when `mem_oe` or `mem_we` is high. It is never high while `sr_clk` or `sr_latch` is high.
- R8: A read produces exactly one `mem_oe` pulse of ACC_CYC clocks, and `mem_we` stays low during it.
- R9: A write produces exactly one `mem_we` pulse of ACC_CYC clocks, with `mem_doe` high and `mem_dout` equal to the request's write data throughout. `mem_oe` stays low.
- R10: `rsp_valid` is high for exactly one cycle per access, in the cycle in which the strobe falls. For a read, `rsp_rdata` holds `mem_din` as sampled in the last cycle of the `mem_oe` pulse.
- R11: A request is accepted only when `req_ready` is high, which is only when no access is in progress. A `req_valid` raised during an access and dropped before the access ends starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Memory address of the request |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Byte returned by the last read |
| sr_data | output | 1 | Serial address bit to the chain |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_latch | output | 1 | Storage-latch pulse to the chain |
| mem_ce | output | 1 | Chip enable, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_we | output | 1 | Write enable, active high |
| mem_doe | output | 1 | Drive `mem_dout` onto the memory data bus |
| mem_dout | output | DATA_W | Write data to the memory |
| mem_din | input | DATA_W | Read data from the memory |

## Verification
A bit counter that is off by one, or a shift in the wrong order, leaves the chain model holding the wrong address. This shows up at the first strobe edge, and a read-back returns a byte from another location. A phase or pacing fault changes the run length of the shift-clock or latch pulse. That is visible within the same bit period. A state machine that leaves the latch state early or skips it moves the strobe rise relative to the last clock fall. This is seen on the first access. A stuck or misdirected strobe decode breaks the chip-enable relation, the single-pulse count or the response timing within one access.

// File: rtl/sr_addr_pkg.sv
// Shared types for the shift-register address driver.
package sr_addr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_LATCH  = 2'd2,
        ST_ACCESS = 2'd3
    } drv_state_e;
endpackage

// File: rtl/sr_addr_pacer.sv
// Half-period pacer: raises half_done once every SH_CYC clocks while run is high.
// Assumes: SH_CYC >= 1; the count restarts at zero whenever run is low.
module sr_addr_pacer #(
    parameter int SH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_done
);
    localparam int CNT_W = (SH_CYC > 1) ? $clog2(SH_CYC) : 1;

    logic [CNT_W-1:0] cnt;

    assign half_done = run && (cnt == CNT_W'(SH_CYC - 1));

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    pacer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/sr_addr_serializer.sv
// Address serializer: holds the address and presents its bits MSB first.
// Assumes: load and shift never occur in the same cycle; ADDR_W >= 2.
module sr_addr_serializer #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              shift,
    output logic              sdata,
    output logic              last_bit
);
    localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;

    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    assign sdata    = shreg[ADDR_W-1];
    assign last_bit = (bit_cnt == CNT_W'(ADDR_W - 1));

    // Load a new address or move to the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (load) begin
            shreg   <= load_addr;
            bit_cnt <= '0;
        end else if (shift) begin
            shreg   <= {shreg[ADDR_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R2
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/sr_addr_driver.sv
// Top: sequences one memory access as shift, optional latch pulse, then strobe.
// Assumes: an external chain that shifts on the rising edge of sr_clk. When
// HAS_LATCH is 0, the chain outputs drive the memory address pins directly.
module sr_addr_driver
    import sr_addr_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int SH_CYC    = 2,
    parameter int ACC_CYC   = 3,
    parameter bit HAS_LATCH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sr_data,
    output logic              sr_clk,
    output logic              sr_latch,
    output logic              mem_ce,
    output logic              mem_oe,
    output logic              mem_we,
    output logic              mem_doe,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int ACC_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
    localparam int LEN_W = $clog2(2 * SH_CYC + 1) + 1;
    localparam drv_state_e AFTER_SHIFT = HAS_LATCH ? ST_LATCH : ST_ACCESS;

    drv_state_e        state;
    logic              phase;
    logic [ACC_W-1:0]  acc_cnt;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic              half_done;
    logic              last_bit;
    logic              load;
    logic              shift;
    logic              acc_last;

    assign load     = (state == ST_IDLE) && req_valid;
    assign shift    = (state == ST_SHIFT) && half_done && phase;
    assign acc_last = (acc_cnt == ACC_W'(ACC_CYC - 1));

    sr_addr_pacer #(.SH_CYC(SH_CYC)) pacer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       ((state == ST_SHIFT) || (state == ST_LATCH)),
        .half_done (half_done)
    );

    sr_addr_serializer #(.ADDR_W(ADDR_W)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (req_addr),
        .shift     (shift),
        .sdata     (sr_data),
        .last_bit  (last_bit)
    );

    // Sequence the access and capture request fields and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= 1'b0;
            acc_cnt   <= '0;
            write_q   <= 1'b0;
            wdata_q   <= '0;
            rsp_rdata <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        phase   <= 1'b0;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (half_done) begin
                        phase <= ~phase;
                        if (phase && last_bit) begin
                            state <= AFTER_SHIFT;
                        end
                    end
                end
                ST_LATCH: begin
                    if (half_done) begin
                        phase <= ~phase;
                        if (phase) begin
                            state <= ST_ACCESS;
                        end
                    end
                end
                default: begin
                    if (acc_last) begin
                        acc_cnt   <= '0;
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                        if (!write_q) begin
                            rsp_rdata <= mem_din;
                        end
                    end else begin
                        acc_cnt <= acc_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Decode pins from the state register.
    assign req_ready = (state == ST_IDLE);
    assign sr_clk    = (state == ST_SHIFT) && phase;
    assign mem_oe    = (state == ST_ACCESS) && !write_q;
    assign mem_we    = (state == ST_ACCESS) && write_q;
    assign mem_doe   = mem_we;
    assign mem_ce    = mem_oe || mem_we;
    assign mem_dout  = wdata_q;

    // Latch pin exists only in the latched build.
    generate
        if (HAS_LATCH) begin : g_latch
            assign sr_latch = (state == ST_LATCH);
        end else begin : g_no_latch
            assign sr_latch = 1'b0;
        end
    endgenerate

    // Checker counter: length of the current latch pulse.
    logic [LEN_W-1:0] chk_latch_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_latch_len <= '0;
        end else if (sr_latch) begin
            chk_latch_len <= chk_latch_len + 1'b1;
        end else begin
            chk_latch_len <= '0;
        end
    end

    // R7
    ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce |-> (!sr_clk && !sr_latch));
    // R4
    latch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_latch |-> !sr_clk);
    // R4
    latch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_latch) |-> (chk_latch_len == LEN_W'(2 * SH_CYC)));
    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_oe && mem_we));
endmodule

// File: tb/sr_addr_driver_tb_top.sv
// Environment: external chain and memory model plus pin-timing checks.
module sr_addr_tb_env #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int SH_CYC    = 2,
    parameter int ACC_CYC   = 3,
    parameter bit HAS_LATCH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_data,
    input  logic              sr_clk,
    input  logic              sr_latch,
    input  logic              mem_ce,
    input  logic              mem_oe,
    input  logic              mem_we,
    input  logic              mem_doe,
    input  logic [DATA_W-1:0] mem_dout,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] exp_addr,
    output logic [DATA_W-1:0] mem_din,
    output int                n_chk,
    output int                n_err,
    output int                n_acc
);
    logic [ADDR_W-1:0] chain, outq, vis, prev_vis;
    logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
    logic prev_clk, prev_lat, prev_stb, stb;
    int hi_cnt, lo_cnt, lat_cnt, rises, since_fall, stb_len;

    initial begin
        chain = '0; outq = '0; prev_vis = '0;
        prev_clk = 0; prev_lat = 0; prev_stb = 0;
        hi_cnt = 0; lo_cnt = 0; lat_cnt = 0; rises = 0; since_fall = 0; stb_len = 0;
        n_chk = 0; n_err = 0; n_acc = 0;
        for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = DATA_W'(i * 37 + 5);
    end

    always @(posedge sr_clk) chain <= {chain[ADDR_W-2:0], sr_data};
    always @(posedge sr_latch) outq <= chain;

    assign vis     = HAS_LATCH ? outq : chain;
    assign stb     = mem_oe || mem_we;
    assign mem_din = (mem_oe && mem_ce) ? mem[vis] : '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s latch=%0d actual=%0d expected=%0d", tag, HAS_LATCH, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(mem_ce == stb, "R7 ce vs oe|we", mem_ce, stb);
            if (mem_ce) chk(!sr_clk && !sr_latch, "R7 ce during shift/latch", sr_clk, 0);
            if (mem_oe) chk(!mem_we, "R8 oe with we", mem_we, 0);
            if (mem_we) begin
                chk(mem_doe, "R9 doe during we", mem_doe, 1);
                mem[vis] = mem_dout;
            end
            if (!HAS_LATCH) begin
                if (sr_latch) chk(0, "R6 latch in no-latch build", 1, 0);
            end else if (sr_latch) begin
                chk(!sr_clk, "R4 clk during latch", sr_clk, 0);
            end
            // shift clock run lengths
            if (prev_clk && !sr_clk) begin
                chk(hi_cnt == SH_CYC, "R3 high length", hi_cnt, SH_CYC);
                since_fall = 0;
            end else begin
                since_fall++;
            end
            if (!prev_clk && sr_clk) begin
                if (rises > 0) chk(lo_cnt == SH_CYC, "R3 low length", lo_cnt, SH_CYC);
                rises++;
            end
            hi_cnt = sr_clk ? hi_cnt + 1 : 0;
            lo_cnt = sr_clk ? 0 : lo_cnt + 1;
            // latch pulse
            if (!prev_lat && sr_latch) chk(rises == ADDR_W, "R2 bits before latch", rises, ADDR_W);
            if (prev_lat && !sr_latch) chk(lat_cnt == 2*SH_CYC, "R4 latch length", lat_cnt, 2*SH_CYC);
            lat_cnt = sr_latch ? lat_cnt + 1 : 0;
            if (HAS_LATCH && vis != prev_vis)
                chk(sr_latch && !prev_lat, "R5 address moved outside latch edge", vis, prev_vis);
            // strobe
            if (!prev_stb && stb) begin
                n_acc++;
                chk(rises == ADDR_W, "R2 bit count", rises, ADDR_W);
                chk(vis == exp_addr, "R2 memory address", vis, exp_addr);
                chk(since_fall == (HAS_LATCH ? 2*SH_CYC : 0), HAS_LATCH ? "R4 strobe after latch" : "R6 strobe after last bit",
                    since_fall, HAS_LATCH ? 2*SH_CYC : 0);
                rises = 0;
            end
            if (prev_stb && !stb) begin
                chk(stb_len == ACC_CYC, "R8 R9 strobe length", stb_len, ACC_CYC);
                chk(rsp_valid, "R10 rsp with strobe fall", rsp_valid, 1);
            end else if (rsp_valid) begin
                chk(0, "R10 rsp outside strobe fall", 1, 0);
            end
            stb_len = stb ? stb_len + 1 : 0;
        end
        prev_clk = sr_clk; prev_lat = sr_latch; prev_stb = stb; prev_vis = vis;
    end
endmodule

// Bench: drives both builds, scoreboard of expected responses.
module sr_addr_driver_tb_top;
    localparam int ADDR_W = 10, DATA_W = 8, SH_CYC = 2, ACC_CYC = 3;

    typedef struct { bit rd; logic [DATA_W-1:0] data; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              rq_valid [2], rq_ready [2], rq_write [2];
    logic [ADDR_W-1:0] rq_addr [2], cur_addr [2];
    logic [DATA_W-1:0] rq_wdata [2], rsp_rdata [2], mem_dout [2], mem_din [2];
    logic              rsp_valid [2], sr_data [2], sr_clk [2], sr_latch [2];
    logic              mem_ce [2], mem_oe [2], mem_we [2], mem_doe [2];
    int                e_chk [2], e_err [2], e_acc [2];
    logic [DATA_W-1:0] ref_mem [2][0:(1<<ADDR_W)-1];
    exp_t q0[$], q1[$];
    int n_chk = 0, n_err = 0, n_txn [2];
    bit done = 0;

    sr_addr_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_CYC(SH_CYC), .ACC_CYC(ACC_CYC), .HAS_LATCH(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_valid[0]), .req_ready(rq_ready[0]), .req_write(rq_write[0]),
        .req_addr(rq_addr[0]), .req_wdata(rq_wdata[0]), .rsp_valid(rsp_valid[0]), .rsp_rdata(rsp_rdata[0]),
        .sr_data(sr_data[0]), .sr_clk(sr_clk[0]), .sr_latch(sr_latch[0]), .mem_ce(mem_ce[0]), .mem_oe(mem_oe[0]),
        .mem_we(mem_we[0]), .mem_doe(mem_doe[0]), .mem_dout(mem_dout[0]), .mem_din(mem_din[0]));

    sr_addr_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_CYC(SH_CYC), .ACC_CYC(ACC_CYC), .HAS_LATCH(1'b0)) dut_nl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(rq_valid[1]), .req_ready(rq_ready[1]), .req_write(rq_write[1]),
        .req_addr(rq_addr[1]), .req_wdata(rq_wdata[1]), .rsp_valid(rsp_valid[1]), .rsp_rdata(rsp_rdata[1]),
        .sr_data(sr_data[1]), .sr_clk(sr_clk[1]), .sr_latch(sr_latch[1]), .mem_ce(mem_ce[1]), .mem_oe(mem_oe[1]),
        .mem_we(mem_we[1]), .mem_doe(mem_doe[1]), .mem_dout(mem_dout[1]), .mem_din(mem_din[1]));

    for (genvar k = 0; k < 2; k++) begin : g_env
        sr_addr_tb_env #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SH_CYC(SH_CYC), .ACC_CYC(ACC_CYC), .HAS_LATCH(k == 0)) env_i (
            .clk(clk), .rst_n(rst_n), .sr_data(sr_data[k]), .sr_clk(sr_clk[k]), .sr_latch(sr_latch[k]),
            .mem_ce(mem_ce[k]), .mem_oe(mem_oe[k]), .mem_we(mem_we[k]), .mem_doe(mem_doe[k]),
            .mem_dout(mem_dout[k]), .rsp_valid(rsp_valid[k]), .exp_addr(cur_addr[k]), .mem_din(mem_din[k]),
            .n_chk(e_chk[k]), .n_err(e_err[k]), .n_acc(e_acc[k]));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items as responses appear.
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_n && rsp_valid[k]) begin
                exp_t e;
                if ((k == 0 ? q0.size() : q1.size()) == 0) begin
                    chk(0, "R11 response with nothing pending", 1, 0);
                end else begin
                    e = (k == 0) ? q0.pop_front() : q1.pop_front();
                    if (e.rd) chk(rsp_rdata[k] === e.data, "R10 read data", rsp_rdata[k], e.data);
                end
            end
            if (rst_n && mem_we[k]) chk(mem_dout[k] === rq_wdata[k], "R9 write data", mem_dout[k], rq_wdata[k]);
        end
    end

    // Driver: one access on build k; optionally raise req_valid while busy.
    task automatic do_txn(input int k, input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input bit poke);
        exp_t e;
        @(negedge clk);
        rq_valid[k] = 1; rq_write[k] = wr; rq_addr[k] = a; rq_wdata[k] = d; cur_addr[k] = a;
        e.rd = !wr; e.data = ref_mem[k][a];
        if (wr) ref_mem[k][a] = d;
        if (k == 0) q0.push_back(e); else q1.push_back(e);
        n_txn[k]++;
        @(negedge clk);
        rq_valid[k] = 0;
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(!rq_ready[k], "R11 ready low while busy", rq_ready[k], 0);
            rq_valid[k] = 1; rq_addr[k] = ~a;
            repeat (3) @(negedge clk);
            rq_valid[k] = 0; rq_addr[k] = a;
        end
        while (!rsp_valid[k]) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            rq_valid[k] = 0; rq_write[k] = 0; rq_addr[k] = '0; rq_wdata[k] = '0; cur_addr[k] = '0; n_txn[k] = 0;
            for (int i = 0; i < (1<<ADDR_W); i++) ref_mem[k][i] = DATA_W'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (8) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            // R1: idle pins after reset
            chk(rq_ready[k] && !rsp_valid[k], "R1 ready/rsp after reset", {rq_ready[k], rsp_valid[k]}, 2);
            chk(!mem_ce[k] && !mem_oe[k] && !mem_we[k] && !mem_doe[k], "R1 strobes after reset",
                {mem_ce[k], mem_oe[k], mem_we[k], mem_doe[k]}, 0);
            chk(!sr_clk[k] && !sr_latch[k], "R1 chain pins after reset", {sr_clk[k], sr_latch[k]}, 0);
        end
        for (int k = 0; k < 2; k++) begin
            do_txn(k, 0, 10'h000, 8'h00, 0);
            do_txn(k, 0, 10'h3FF, 8'h00, 0);
            do_txn(k, 1, 10'h000, 8'h5A, 0);
            do_txn(k, 1, 10'h3FF, 8'hC3, 0);
            do_txn(k, 1, 10'h2AA, 8'hFF, 0);
            do_txn(k, 1, 10'h155, 8'h00, 1);
            for (int i = 0; i < 8; i++)
                do_txn(k, 1, ADDR_W'(i * 97 + 13), DATA_W'(i * 29 + 1), 0);
            do_txn(k, 0, 10'h000, 8'h00, 0);
            do_txn(k, 0, 10'h3FF, 8'h00, 0);
            do_txn(k, 0, 10'h2AA, 8'h00, 1);
            do_txn(k, 0, 10'h155, 8'h00, 0);
            for (int i = 0; i < 8; i++)
                do_txn(k, 0, ADDR_W'(i * 97 + 13), 8'h00, 0);
            do_txn(k, 1, 10'h2AA, 8'h81, 0);
            do_txn(k, 0, 10'h2AA, 8'h00, 0);
            do_txn(k, 0, 10'h1F0, 8'h00, 0);
        end
        repeat (10) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            // R11: ignored requests left no extra accesses
            chk(e_acc[k] == n_txn[k], "R11 access count", e_acc[k], n_txn[k]);
            chk((k == 0 ? q0.size() : q1.size()) == 0, "R10 missing responses", k == 0 ? q0.size() : q1.size(), 0);
        end
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk + e_chk[0] + e_chk[1], n_err + e_err[0] + e_err[1]);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL R10 watchdog expired actual=running expected=complete");
            $display("  CHECKS %0d ERRORS %0d", n_chk + e_chk[0] + e_chk[1], n_err + e_err[0] + e_err[1]);
            $finish;
        end
    end
endmodule